// File: doc/BRIEF.md
# SIMT Branch Divergence Mask Unit

This unit holds the lane-enable mask of a single warp and updates it as the warp passes through if/else branches. When a branch arrives, the unit reads one predicate bit per lane. Only lanes that are active count. If all active lanes agree, the branch is uniform and runs once. If they disagree, the unit runs two passes one after the other: first the lanes whose predicate is true, then the active lanes whose predicate is false. After the last pass, the mask goes back to the value it had before the branch.

The instruction side raises `path_done` when the current path reaches its end. The unit then either moves to the pending else-lanes or reconverges. A stack with one entry per open branch holds each branch's outer mask, its pending else-lanes, its current phase and its pass tally. This lets branches nest. A branch that would push onto a full stack is dropped and raises a sticky error flag. On each reconvergence the unit reports how many path executions the finished branch used.

Top module: `simt_mask_unit`

## Requirements
- R1: After reset, `act_mask` is all ones, `depth` is 0, and `on_else`, `passes`, `reconv` and `ovf_err` are all 0.
- R2: A branch (`br_valid`) with a non-full stack, where some but not all active lanes have their predicate set, makes `act_mask` equal to the old mask AND the predicate on the next cycle. `on_else` becomes 0 and `depth` rises by 1.
- R3: `path_done` during the if path of a divergent branch makes `act_mask` equal to the pre-branch mask AND NOT the predicate on the next cycle, and `on_else` becomes 1.
- R4: `path_done` on the final path of a branch restores the pre-branch mask and lowers `depth` by 1. It also pulses `reconv` for exactly one cycle and loads `passes` with the number of paths the branch ran. The final path is the else path, or the if path when the else-lanes are empty.
- R5: A branch whose predicate covers every active lane leaves `act_mask` unchanged with `on_else`=0. One `path_done` reconverges it with `passes`=1.
- R6: A branch whose predicate covers no active lane skips the if path. On the next cycle `on_else` is 1 and `act_mask` is unchanged. One `path_done` reconverges it with `passes`=1.
- R7: The alternating predicate 32'h55555555 on a full mask runs 16 lanes per pass, first 32'h55555555 and then 32'hAAAAAAAA, and ends with `passes`=2.
- R8: A nested branch splits the current `act_mask`; predicate bits of inactive lanes are ignored. On its reconvergence the outer path's mask and its `on_else` value come back.
- R9: A branch that arrives with `depth` equal to DEPTH (4) sets `ovf_err`, which stays set until reset. It changes neither `act_mask` nor `depth`.
- R10: `path_done` with `depth` 0 has no effect. When `br_valid` and `path_done` are high in the same cycle, the branch is taken and `path_done` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| br_valid | input | 1 | Branch issued this cycle |
| br_pred | input | LANES | Per-lane branch predicate |
| path_done | input | 1 | Current path has reached its end |
| act_mask | output | LANES | Lanes enabled for execution |
| on_else | output | 1 | Innermost branch is on its else path |
| depth | output | $clog2(DEPTH+1) | Number of open branches |
| passes | output | 2 | Path executions used by the last reconverged branch |
| reconv | output | 1 | One-cycle pulse at reconvergence |
| ovf_err | output | 1 | Sticky stack-overflow flag |

## Verification
The bench checks both uniform directions: with all lanes agreeing and with none agreeing. A design that always runs two passes would report a pass count of 2 there, or show an empty mask. It checks the alternating predicate and nesting two levels deep, including an inner branch opened on an outer else path. A unit that restored the wrong entry, or lost the outer phase, would return a wrong mask or `on_else`. It also checks a branch pushed onto a full stack, a `path_done` with no branch open, and a `path_done` that coincides with a branch. A faulty unit would corrupt the mask, pop early or clear the error flag.

// File: rtl/simt_mask_unit.sv
module simt_mask_unit #(
  parameter int LANES = 32,
  parameter int DEPTH = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         br_valid,
  input  logic [LANES-1:0]             br_pred,
  input  logic                         path_done,
  output logic [LANES-1:0]             act_mask,
  output logic                         on_else,
  output logic [$clog2(DEPTH+1)-1:0]   depth,
  output logic [1:0]                   passes,
  output logic                         reconv,
  output logic                         ovf_err
);
  localparam int DW = $clog2(DEPTH+1);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [LANES-1:0] outer_q [DEPTH];
  logic [LANES-1:0] alt_q   [DEPTH];
  logic             phase_q [DEPTH];
  logic [1:0]       cnt_q   [DEPTH];

  wire [LANES-1:0] taken = act_mask & br_pred;
  wire [LANES-1:0] other = act_mask & ~br_pred;
  wire             full  = (depth == DW'(DEPTH));
  wire             empty = (depth == '0);
  wire [AW-1:0]    wr_i  = AW'(depth);
  wire [AW-1:0]    top_i = AW'(depth - DW'(1));
  wire [AW-1:0]    low_i = AW'(depth - DW'(2));

  wire do_push   = br_valid & ~full;
  wire done_ok   = path_done & ~br_valid & ~empty;
  wire to_else   = done_ok & ~phase_q[top_i] & (|alt_q[top_i]);
  wire do_pop    = done_ok & ~to_else;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_mask <= '1;
      on_else  <= 1'b0;
      depth    <= '0;
      passes   <= 2'd0;
      reconv   <= 1'b0;
      ovf_err  <= 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
        outer_q[i] <= '0;
        alt_q[i]   <= '0;
        phase_q[i] <= 1'b0;
        cnt_q[i]   <= 2'd0;
      end
    end else begin
      reconv <= 1'b0;
      if (br_valid && full) ovf_err <= 1'b1;
      if (do_push) begin
        outer_q[wr_i] <= act_mask;
        cnt_q[wr_i]   <= 2'd1;
        depth         <= depth + DW'(1);
        if (taken == '0) begin
          alt_q[wr_i]   <= '0;
          phase_q[wr_i] <= 1'b1;
          act_mask      <= other;
          on_else       <= 1'b1;
        end else begin
          alt_q[wr_i]   <= other;
          phase_q[wr_i] <= 1'b0;
          act_mask      <= taken;
          on_else       <= 1'b0;
        end
      end else if (to_else) begin
        act_mask       <= alt_q[top_i];
        phase_q[top_i] <= 1'b1;
        cnt_q[top_i]   <= cnt_q[top_i] + 2'd1;
        on_else        <= 1'b1;
      end else if (do_pop) begin
        act_mask <= outer_q[top_i];
        passes   <= cnt_q[top_i];
        reconv   <= 1'b1;
        depth    <= depth - DW'(1);
        on_else  <= (depth > DW'(1)) ? phase_q[low_i] : 1'b0;
      end
    end
  end
endmodule

// File: rtl/simt_mask_unit_chk.sv
module simt_mask_unit_chk #(
  parameter int LANES = 32,
  parameter int DEPTH = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       br_valid,
  input logic [LANES-1:0]           br_pred,
  input logic                       path_done,
  input logic [LANES-1:0]           act_mask,
  input logic                       on_else,
  input logic [$clog2(DEPTH+1)-1:0] depth,
  input logic [1:0]                 passes,
  input logic                       reconv,
  input logic                       ovf_err
);
  localparam int DW = $clog2(DEPTH+1);

  // R2
  p_split_taken_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && depth != DW'(DEPTH) && (act_mask & br_pred) != '0 && (act_mask & ~br_pred) != '0)
    |=> (act_mask == $past(act_mask & br_pred)) && !on_else && depth == $past(depth) + DW'(1));

  // R4
  p_reconv_pop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reconv |-> (depth == $past(depth) - DW'(1)) && passes != 2'd0 && passes <= 2'd2);

  // R6
  p_skip_if_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && depth != DW'(DEPTH) && (act_mask & br_pred) == '0)
    |=> on_else && $stable(act_mask));

  // R9
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && depth == DW'(DEPTH)) |=> ovf_err && $stable(act_mask) && $stable(depth));

  // R9
  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err |=> ovf_err);

  // R10
  p_idle_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (path_done && !br_valid && depth == '0) |=> $stable(act_mask) && !reconv && depth == '0);

  // R4
  p_reconv_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reconv |=> !reconv || $past(path_done));
endmodule

bind simt_mask_unit simt_mask_unit_chk #(.LANES(LANES), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_pred(br_pred),
  .path_done(path_done), .act_mask(act_mask), .on_else(on_else),
  .depth(depth), .passes(passes), .reconv(reconv), .ovf_err(ovf_err)
);

// File: tb/simt_mask_unit_tb.sv
module simt_mask_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        br_valid = 1'b0;
  logic [31:0] br_pred = '0;
  logic        path_done = 1'b0;
  logic [31:0] act_mask;
  logic        on_else;
  logic [2:0]  depth;
  logic [1:0]  passes;
  logic        reconv;
  logic        ovf_err;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  simt_mask_unit #(.LANES(32), .DEPTH(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_pred(br_pred),
    .path_done(path_done), .act_mask(act_mask), .on_else(on_else),
    .depth(depth), .passes(passes), .reconv(reconv), .ovf_err(ovf_err)
  );

  // {pred, first-pass mask, first on_else, expected passes}
  localparam logic [66:0] VEC [6] = '{
    {32'hFFFFFFFF, 32'hFFFFFFFF, 1'b0, 2'd1},   // R5
    {32'h00000000, 32'hFFFFFFFF, 1'b1, 2'd1},   // R6
    {32'h55555555, 32'h55555555, 1'b0, 2'd2},   // R7
    {32'h0000FFFF, 32'h0000FFFF, 1'b0, 2'd2},   // R2
    {32'h80000000, 32'h80000000, 1'b0, 2'd2},   // R2
    {32'h7FFFFFFF, 32'h7FFFFFFF, 1'b0, 2'd2}    // R2
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic branch(input logic [31:0] p, input logic with_done);
    br_valid = 1'b1; br_pred = p; path_done = with_done;
    @(negedge clk);
    br_valid = 1'b0; path_done = 1'b0;
  endtask

  task automatic done();
    path_done = 1'b1;
    @(negedge clk);
    path_done = 1'b0;
  endtask

  task automatic check_reset(input string req);
    chk(req, act_mask, 32'hFFFFFFFF);
    chk(req, {29'd0, depth}, 32'd0);
    chk(req, {28'd0, on_else, passes, reconv}, 32'd0);
    chk(req, {31'd0, ovf_err}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check_reset("R1");
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < 6; v++) begin
      logic [31:0] p, m1;
      logic e1;
      logic [1:0] np;
      {p, m1, e1, np} = VEC[v];
      branch(p, 1'b0);
      chk("R2/R5/R6 first mask", act_mask, m1);
      chk("R2/R5/R6 first phase", {31'd0, on_else}, {31'd0, e1});
      chk("R2 depth", {29'd0, depth}, 32'd1);
      done();
      if (np == 2'd2) begin
        chk("R3/R7 else mask", act_mask, ~p);
        chk("R3 else phase", {31'd0, on_else}, 32'd1);
        chk("R3 no reconv yet", {31'd0, reconv}, 32'd0);
        done();
      end
      chk("R4 restore", act_mask, 32'hFFFFFFFF);
      chk("R4 reconv pulse", {31'd0, reconv}, 32'd1);
      chk("R4/R5/R6/R7 passes", {30'd0, passes}, {30'd0, np});
      chk("R4 depth", {29'd0, depth}, 32'd0);
      @(negedge clk);
      chk("R4 pulse width", {31'd0, reconv}, 32'd0);
    end

    // R8 nesting
    branch(32'h0000FFFF, 1'b0);
    branch(32'h000000FF, 1'b0);
    chk("R8 inner mask", act_mask, 32'h000000FF);
    chk("R8 depth 2", {29'd0, depth}, 32'd2);
    done();
    chk("R8 inner else", act_mask, 32'h0000FF00);
    done();
    chk("R8 back to outer if", act_mask, 32'h0000FFFF);
    chk("R8 outer phase", {31'd0, on_else}, 32'd0);
    chk("R8 inner passes", {30'd0, passes}, 32'd2);
    done();
    chk("R8 outer else", act_mask, 32'hFFFF0000);
    branch(32'hFFFFFFFF, 1'b0);
    chk("R8 inactive pred ignored", act_mask, 32'hFFFF0000);
    chk("R8 inner phase", {31'd0, on_else}, 32'd0);
    done();
    chk("R8 restore outer else", act_mask, 32'hFFFF0000);
    chk("R8 outer else phase back", {31'd0, on_else}, 32'd1);
    chk("R8 inner uniform passes", {30'd0, passes}, 32'd1);
    done();
    chk("R8 final restore", act_mask, 32'hFFFFFFFF);
    chk("R8 outer passes", {30'd0, passes}, 32'd2);

    // R10
    done();
    chk("R10 idle done mask", act_mask, 32'hFFFFFFFF);
    chk("R10 idle done reconv", {31'd0, reconv}, 32'd0);
    branch(32'h0000000F, 1'b1);
    chk("R10 branch wins mask", act_mask, 32'h0000000F);
    chk("R10 branch wins depth", {29'd0, depth}, 32'd1);
    done();
    done();
    chk("R10 cleanup", act_mask, 32'hFFFFFFFF);

    // R9
    for (int k = 0; k < 4; k++) branch(32'hFFFFFFFF, 1'b0);
    chk("R9 full depth", {29'd0, depth}, 32'd4);
    chk("R9 no err yet", {31'd0, ovf_err}, 32'd0);
    branch(32'h00000001, 1'b0);
    chk("R9 err set", {31'd0, ovf_err}, 32'd1);
    chk("R9 mask kept", act_mask, 32'hFFFFFFFF);
    chk("R9 depth kept", {29'd0, depth}, 32'd4);
    for (int k = 0; k < 4; k++) done();
    chk("R9 drained", {29'd0, depth}, 32'd0);
    chk("R9 sticky", {31'd0, ovf_err}, 32'd1);

    rst_n = 1'b0;
    @(negedge clk);
    check_reset("R1 after err");

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule